// File: doc/BRIEF.md
# Snoop Inquire Writeback Address Tracker

This block sits on the system side of a cache-coherent processor bus. When system logic asks it to snoop a cache line, it issues a one-cycle external address strobe carrying the line address, optionally with an invalidate request. It then samples the processor's hit and hit-modified replies at a fixed delay after the strobe. A clean hit or a miss closes the snoop at once. A hit to a modified line means the processor will write the line back as a four-beat burst, so the block follows that writeback through to its end.

During the writeback the block supplies the address of every beat. The line part of the address comes from one of two places. If address hold is still asserted when the writeback starts, the processor cannot drive the address bus, so the block uses its own copy of the inquire line, captured when the strobe went out. If hold has been released, the block takes the line and starting beat that the processor drives with its address strobe. The block then steps the beat index in the processor's interleaved burst order on each ready. The snoop counts as finished only when hit-modified drops after the last ready. A busy flag stays high until then, and a done pulse with a result code reports the outcome.

Top module: `snp_wb_tracker`

## Requirements
- R1: After reset, busy_o, eads_o, inv_o, wb_valid_o and done_o are all low.
- R2: A request on req_valid_i while busy_o is low drives eads_o high for exactly one cycle, in the following cycle, with snp_line_o equal to the requested line. busy_o is high from that cycle through the done cycle inclusive.
- R3: inv_o is high together with eads_o exactly when req_inv_i was high with the accepted request, and is never high at any other time.
- R4: A request made while busy_o is high is ignored: it causes no extra strobe, and the line and invalidate of the snoop in progress are unchanged.
- R5: hit_i and hitm_i are sampled only in the cycle two clocks after the strobe. If hitm_i is low there, done_o pulses in that same cycle with code 1 (clean) if hit_i is high and code 0 (miss) otherwise. Hit levels in other cycles have no effect.
- R6: If hitm_i is high at the sample point, the block waits for ads_i. On ads_i the writeback line is the captured inquire line when hold_i is high, and cpu_addr_i bits [ADDR_W-1:5] when hold_i is low.
- R7: The starting beat is 0 when hold_i is high at ads_i, and cpu_addr_i bits [4:3] otherwise. Beat k carries the index start XOR k in wb_addr_o bits [1:0], which are address bits 4:3. wb_valid_o is high from the cycle after ads_i through the cycle of the fourth brdy_i. The beat advances only on brdy_i, and brdy_i outside that window has no effect.
- R8: After the fourth brdy_i, done_o pulses with code 2 (modified, written back) in the first cycle in which hitm_i is low. busy_o is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid_i | input | 1 | Request to snoop a line |
| req_line_i | input | 27 | Line address (address bits 31:5) to snoop |
| req_inv_i | input | 1 | Ask the processor to invalidate the line |
| hold_i | input | 1 | Address hold currently asserted to the processor |
| hit_i | input | 1 | Processor reports the line present |
| hitm_i | input | 1 | Processor reports the line modified |
| ads_i | input | 1 | Processor address strobe starting the writeback |
| cpu_addr_i | input | 29 | Address bits 31:3 driven by the processor |
| brdy_i | input | 1 | Burst ready, one per transferred beat |
| busy_o | output | 1 | Snoop in progress; new requests are ignored |
| eads_o | output | 1 | External address strobe for the inquire |
| inv_o | output | 1 | Invalidate request, valid with eads_o |
| snp_line_o | output | 27 | Latched inquire line address |
| wb_valid_o | output | 1 | wb_addr_o carries the current writeback beat |
| wb_addr_o | output | 29 | Writeback beat address, bits 31:3 |
| done_o | output | 1 | One-cycle completion pulse |
| done_code_o | output | 2 | 0 miss, 1 clean hit, 2 modified and written back |

## Verification
The bench drives the writeback with hold kept asserted while the processor puts a misleading address on the bus. A block that picked the wrong address source would emit that stray line or a non-zero starting beat. It also starts a released-hold writeback at beat 2 with wait states, so a linear counter or a step taken without a ready would show a wrong beat sequence. Hit pulses one cycle early, a stray ready before the address strobe, a request while busy, and a hit-modified held several cycles past the last ready probe the timing edges. A block that got any of these wrong would end early, duplicate the strobe, or overwrite its latched line.

// File: rtl/snp_pkg.sv
// Shared types for the snoop writeback tracker.
package snp_pkg;

    // Phases of one snoop transaction.
    typedef enum logic [2:0] {
        S_IDLE,
        S_ISSUE,
        S_RESP,
        S_WB_WAIT,
        S_WB_BURST,
        S_WB_TAIL
    } snp_state_t;

    // Outcome reported with the done pulse.
    typedef enum logic [1:0] {
        DONE_MISS  = 2'd0,
        DONE_CLEAN = 2'd1,
        DONE_DIRTY = 2'd2
    } done_code_t;

endpackage

// File: rtl/snp_inquire_seq.sv
// Sequencer for one snoop: issues the strobe, waits the response latency,
// samples hit/hitm, follows the writeback phases and reports completion.
// Assumes ready only arrives after the writeback address strobe and that
// hitm stays high until after the last ready.
module snp_inquire_seq
    import snp_pkg::*;
#(
    parameter int LINE_W    = 27,
    parameter int SNOOP_LAT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic [LINE_W-1:0] req_line_i,
    input  logic              req_inv_i,
    input  logic              hit_i,
    input  logic              hitm_i,
    input  logic              ads_i,
    input  logic              brdy_i,
    input  logic              last_beat_i,
    output logic              busy_o,
    output logic              eads_o,
    output logic              inv_o,
    output logic [LINE_W-1:0] inq_line_o,
    output logic              wb_start_o,
    output logic              beat_adv_o,
    output logic              wb_valid_o,
    output logic              done_o,
    output done_code_t        done_code_o
);
    localparam int LAT_W = $clog2(SNOOP_LAT + 1);

    snp_state_t        state_q, state_d;
    logic [LAT_W-1:0]  lat_q, lat_d;
    logic [LINE_W-1:0] line_q;
    logic              inv_q;
    logic              sample_now;

    // Response sample point: the configured number of clocks after the strobe.
    assign sample_now = (state_q == S_RESP) && (lat_q == LAT_W'(SNOOP_LAT));

    // State and latency counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            lat_q   <= '0;
        end else begin
            state_q <= state_d;
            lat_q   <= lat_d;
        end
    end

    // Capture the inquire line and invalidate flag when a request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
            inv_q  <= 1'b0;
        end else if (state_q == S_IDLE && req_valid_i) begin
            line_q <= req_line_i;
            inv_q  <= req_inv_i;
        end
    end

    // Next-state logic across the snoop phases.
    always_comb begin
        state_d = state_q;
        lat_d   = lat_q;
        unique case (state_q)
            S_IDLE:     if (req_valid_i) state_d = S_ISSUE;
            S_ISSUE: begin
                state_d = S_RESP;
                lat_d   = LAT_W'(1);
            end
            S_RESP: begin
                if (sample_now) state_d = hitm_i ? S_WB_WAIT : S_IDLE;
                else            lat_d   = lat_q + LAT_W'(1);
            end
            S_WB_WAIT:  if (ads_i) state_d = S_WB_BURST;
            S_WB_BURST: if (brdy_i && last_beat_i) state_d = S_WB_TAIL;
            S_WB_TAIL:  if (!hitm_i) state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    // Outputs decoded from the current phase.
    always_comb begin
        busy_o      = (state_q != S_IDLE);
        eads_o      = (state_q == S_ISSUE);
        inv_o       = (state_q == S_ISSUE) && inv_q;
        inq_line_o  = line_q;
        wb_start_o  = (state_q == S_WB_WAIT) && ads_i;
        beat_adv_o  = (state_q == S_WB_BURST) && brdy_i;
        wb_valid_o  = (state_q == S_WB_BURST);
        done_o      = 1'b0;
        done_code_o = DONE_MISS;
        if (sample_now && !hitm_i) begin
            done_o      = 1'b1;
            done_code_o = hit_i ? DONE_CLEAN : DONE_MISS;
        end else if (state_q == S_WB_TAIL && !hitm_i) begin
            done_o      = 1'b1;
            done_code_o = DONE_DIRTY;
        end
    end

endmodule

// File: rtl/snp_wb_addr_gen.sv
// Writeback beat address generator: picks the line and start beat at the
// writeback strobe (latched inquire line under hold, processor address
// otherwise) and steps the beat index on each ready.
// Assumes wb_start_i and beat_adv_i never coincide.
module snp_wb_addr_gen #(
    parameter int LINE_W       = 27,
    parameter int BEAT_W       = 2,
    parameter bit LINEAR_ORDER = 1'b0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [LINE_W-1:0]        inq_line_i,
    input  logic [LINE_W-1:0]        cpu_line_i,
    input  logic [BEAT_W-1:0]        cpu_beat_i,
    input  logic                     hold_i,
    input  logic                     wb_start_i,
    input  logic                     beat_adv_i,
    output logic [LINE_W+BEAT_W-1:0] wb_addr_o,
    output logic                     last_beat_o
);
    logic [LINE_W-1:0] base_q;
    logic [BEAT_W-1:0] start_q;
    logic [BEAT_W-1:0] cnt_q;
    logic [BEAT_W-1:0] beat;

    // Select the address source and reset the beat count at the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            start_q <= '0;
            cnt_q   <= '0;
        end else if (wb_start_i) begin
            base_q  <= hold_i ? inq_line_i : cpu_line_i;
            start_q <= hold_i ? '0 : cpu_beat_i;
            cnt_q   <= '0;
        end else if (beat_adv_i) begin
            cnt_q   <= cnt_q + BEAT_W'(1);
        end
    end

    // Beat ordering variant chosen by parameter.
    generate
        if (LINEAR_ORDER) begin : g_linear
            // Wrap-around linear order.
            always_comb beat = start_q + cnt_q;
        end else begin : g_interleave
            // Interleaved order: start index XOR beat count.
            always_comb beat = start_q ^ cnt_q;
        end
    endgenerate

    assign wb_addr_o   = {base_q, beat};
    assign last_beat_o = &cnt_q;

endmodule

// File: rtl/snp_wb_tracker.sv
// Top of the snoop writeback tracker: sequencer plus beat address generator.
// Assumes 32-byte lines of four 8-byte beats by default.
module snp_wb_tracker
    import snp_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int BEAT_BYTES = 8,
    parameter int SNOOP_LAT  = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid_i,
    input  logic [ADDR_W-$clog2(LINE_BYTES)-1:0] req_line_i,
    input  logic                          req_inv_i,
    input  logic                          hold_i,
    input  logic                          hit_i,
    input  logic                          hitm_i,
    input  logic                          ads_i,
    input  logic [ADDR_W-$clog2(BEAT_BYTES)-1:0] cpu_addr_i,
    input  logic                          brdy_i,
    output logic                          busy_o,
    output logic                          eads_o,
    output logic                          inv_o,
    output logic [ADDR_W-$clog2(LINE_BYTES)-1:0] snp_line_o,
    output logic                          wb_valid_o,
    output logic [ADDR_W-$clog2(BEAT_BYTES)-1:0] wb_addr_o,
    output logic                          done_o,
    output logic [1:0]                    done_code_o
);
    localparam int OFF_W      = $clog2(LINE_BYTES);
    localparam int BEAT_OFF_W = $clog2(BEAT_BYTES);
    localparam int LINE_W     = ADDR_W - OFF_W;
    localparam int BEAT_W     = OFF_W - BEAT_OFF_W;

    logic       wb_start;
    logic       beat_adv;
    logic       last_beat;
    done_code_t code;

    snp_inquire_seq #(
        .LINE_W    (LINE_W),
        .SNOOP_LAT (SNOOP_LAT)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid_i (req_valid_i),
        .req_line_i  (req_line_i),
        .req_inv_i   (req_inv_i),
        .hit_i       (hit_i),
        .hitm_i      (hitm_i),
        .ads_i       (ads_i),
        .brdy_i      (brdy_i),
        .last_beat_i (last_beat),
        .busy_o      (busy_o),
        .eads_o      (eads_o),
        .inv_o       (inv_o),
        .inq_line_o  (snp_line_o),
        .wb_start_o  (wb_start),
        .beat_adv_o  (beat_adv),
        .wb_valid_o  (wb_valid_o),
        .done_o      (done_o),
        .done_code_o (code)
    );

    snp_wb_addr_gen #(
        .LINE_W       (LINE_W),
        .BEAT_W       (BEAT_W),
        .LINEAR_ORDER (1'b0)
    ) u_addr (
        .clk         (clk),
        .rst_n       (rst_n),
        .inq_line_i  (snp_line_o),
        .cpu_line_i  (cpu_addr_i[ADDR_W-BEAT_OFF_W-1:BEAT_W]),
        .cpu_beat_i  (cpu_addr_i[BEAT_W-1:0]),
        .hold_i      (hold_i),
        .wb_start_i  (wb_start),
        .beat_adv_i  (beat_adv),
        .wb_addr_o   (wb_addr_o),
        .last_beat_o (last_beat)
    );

    assign done_code_o = code;

endmodule

// File: rtl/snp_wb_tracker_chk.sv
// Protocol checker for the snoop writeback tracker, bound to the top.
module snp_wb_tracker_chk #(
    parameter int WBA_W  = 29,
    parameter int BEAT_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             eads_o,
    input logic             inv_o,
    input logic             busy_o,
    input logic             done_o,
    input logic [1:0]       done_code_o,
    input logic             wb_valid_o,
    input logic [WBA_W-1:0] wb_addr_o,
    input logic             brdy_i,
    input logic             hitm_i
);
    // R2: strobe lasts one cycle only
    a_r2_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        eads_o |=> !eads_o);

    // R2: the strobe happens inside a busy window
    a_r2_strobe_busy: assert property (@(posedge clk) disable iff (!rst_n)
        eads_o |-> busy_o);

    // R3: invalidate only rides with the strobe
    a_r3_inv_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        inv_o |-> eads_o);

    // R5: a short snoop never finishes during a writeback burst
    a_r5_done_outside_burst: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !wb_valid_o);

    // R6: the line part stays fixed across the burst
    a_r6_line_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid_o && $past(wb_valid_o)) |->
        (wb_addr_o[WBA_W-1:BEAT_W] == $past(wb_addr_o[WBA_W-1:BEAT_W])));

    // R7: without ready the beat address holds
    a_r7_hold_without_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid_o && !brdy_i) |=> (wb_valid_o && $stable(wb_addr_o)));

    // R8: modified completion only once hitm has dropped
    a_r8_dirty_after_hitm: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && done_code_o == 2'd2) |-> !hitm_i);

    // R8: busy clears right after completion
    a_r8_done_releases: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);

endmodule

bind snp_wb_tracker snp_wb_tracker_chk #(
    .WBA_W  (ADDR_W - BEAT_OFF_W),
    .BEAT_W (BEAT_W)
) u_chk (.*);

// File: tb/snp_wb_tracker_test.sv
`timescale 1ns/1ps
module snp_wb_tracker_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid_i, req_inv_i, hold_i, hit_i, hitm_i, ads_i, brdy_i;
    logic [26:0] req_line_i;
    logic [28:0] cpu_addr_i;
    logic        busy_o, eads_o, inv_o, wb_valid_o, done_o;
    logic [26:0] snp_line_o;
    logic [28:0] wb_addr_o;
    logic [1:0]  done_code_o;

    int checks = 0;
    int errors = 0;

    // reference model state
    int          m_phase = 0;   // 0 idle 1 strobe 2 response 3 wait ads 4 burst 5 tail
    int          m_age   = 0;
    logic [26:0] m_line  = '0;
    logic        m_inv   = 1'b0;
    logic [28:0] m_beats[$];

    always #10 clk = ~clk;

    snp_wb_tracker uut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Compare all outputs against the model, then advance the model by one clock.
    task automatic step();
        logic        e_done;
        logic [1:0]  e_code;
        #2;
        e_done = 1'b0;
        e_code = 2'd0;
        if (m_phase == 2 && m_age == 2 && !hitm_i) begin
            e_done = 1'b1;
            e_code = hit_i ? 2'd1 : 2'd0;
        end
        if (m_phase == 5 && !hitm_i) begin
            e_done = 1'b1;
            e_code = 2'd2;
        end
        chk("R2 busy", 32'(busy_o), 32'(m_phase != 0));
        chk("R2 strobe", 32'(eads_o), 32'(m_phase == 1));
        chk("R3 invalidate", 32'(inv_o), 32'(m_phase == 1 && m_inv));
        if (m_phase == 1) chk("R4 strobe line", 32'(snp_line_o), 32'(m_line));
        chk(m_phase == 5 ? "R8 done" : "R5 done", 32'(done_o), 32'(e_done));
        if (e_done) chk(m_phase == 5 ? "R8 code" : "R5 code", 32'(done_code_o), 32'(e_code));
        chk("R7 beat valid", 32'(wb_valid_o), 32'(m_phase == 4));
        if (m_phase == 4) chk("R6 R7 beat address", 32'(wb_addr_o), 32'(m_beats[0]));
        case (m_phase)
            0: if (req_valid_i) begin
                   m_line  = req_line_i;
                   m_inv   = req_inv_i;
                   m_phase = 1;
               end
            1: begin m_phase = 2; m_age = 1; end
            2: if (m_age == 2) m_phase = hitm_i ? 3 : 0;
               else m_age++;
            3: if (ads_i) begin
                   for (int k = 0; k < 4; k++) begin
                       logic [1:0] st;
                       st = hold_i ? 2'd0 : cpu_addr_i[1:0];
                       m_beats.push_back({hold_i ? m_line : cpu_addr_i[28:2], st ^ 2'(k)});
                   end
                   m_phase = 4;
               end
            4: if (brdy_i) begin
                   void'(m_beats.pop_front());
                   if (m_beats.size() == 0) m_phase = 5;
               end
            5: if (!hitm_i) m_phase = 0;
            default: m_phase = 0;
        endcase
        @(negedge clk);
    endtask

    // One snoop with a scripted processor reply.
    task automatic snoop(input logic [26:0] line, input logic inv, input int resp,
                         input logic hold, input logic [28:0] cpu_a, input int ads_gap,
                         input int brdy_wait, input int tail_extra, input bit poke,
                         input bit early, input bit stray);
        req_valid_i = 1'b1; req_line_i = line; req_inv_i = inv; hold_i = hold;
        step();
        req_valid_i = 1'b0; req_line_i = ~line;
        if (poke) begin req_valid_i = 1'b1; req_inv_i = ~inv; end  // R4 ignored request
        step();
        if (poke) begin req_valid_i = 1'b1; req_inv_i = ~inv; end
        if (early) begin hit_i = 1'b1; hitm_i = 1'b1; end             // R5 wrong cycle
        step();
        req_valid_i = 1'b0;
        hit_i  = (resp != 0);
        hitm_i = (resp == 2);
        step();
        hit_i = 1'b0;
        if (resp != 2) begin
            hitm_i = 1'b0;
            step();
            return;
        end
        for (int g = 1; g < ads_gap; g++) begin
            brdy_i = stray && (g == 1);   // R7 stray ready before writeback strobe
            step();
        end
        brdy_i = 1'b0; ads_i = 1'b1; cpu_addr_i = cpu_a;
        step();
        ads_i = 1'b0; cpu_addr_i = ~cpu_a;
        for (int b = 0; b < 4; b++) begin
            for (int w = 0; w < brdy_wait; w++) step();
            brdy_i = 1'b1;
            step();
            brdy_i = 1'b0;
        end
        for (int t = 0; t <= tail_extra; t++) step();
        hitm_i = 1'b0;
        step();
        step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        req_valid_i = 0; req_inv_i = 0; hold_i = 0; hit_i = 0; hitm_i = 0;
        ads_i = 0; brdy_i = 0; req_line_i = '0; cpu_addr_i = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        #2;
        chk("R1 busy", 32'(busy_o), 0);
        chk("R1 strobe", 32'(eads_o), 0);
        chk("R1 invalidate", 32'(inv_o), 0);
        chk("R1 beat valid", 32'(wb_valid_o), 0);
        chk("R1 done", 32'(done_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
        step();
        // miss, no invalidate
        snoop(27'h1234567, 1'b0, 0, 1'b0, '0, 1, 0, 0, 0, 0, 0);
        // clean hit with invalidate
        snoop(27'h7654321, 1'b1, 1, 1'b1, '0, 1, 0, 0, 0, 0, 0);
        // modified, hold kept: latched line, beat 0, processor address ignored
        snoop(27'h0ABCDEF, 1'b1, 2, 1'b1, 29'h1FFFFFFE, 2, 0, 0, 0, 0, 0);
        // modified, hold released: processor line, start beat 2, wait states
        snoop(27'h0111111, 1'b0, 2, 1'b0, 29'h0ABCDE6, 3, 2, 0, 0, 0, 0);
        // request while busy, early hit pulse, then miss
        snoop(27'h5555555, 1'b0, 0, 1'b0, '0, 1, 0, 0, 1, 1, 0);
        // modified with stray ready, start beat 1, long hitm tail
        snoop(27'h2AAAAAA, 1'b1, 2, 1'b0, 29'h1234565, 3, 1, 3, 0, 0, 1);
        // modified, hold kept, start beat 3 offered but ignored
        snoop(27'h3C3C3C3, 1'b0, 2, 1'b1, 29'h0F0F0F3, 1, 0, 0, 1, 0, 0);
        repeat (3) step();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule